// File: doc/BRIEF.md
# Memory-Window Bridge to Byte-Port and Indexed-Word Register Buses

This block turns a 4 KiB memory-mapped window into traffic on two narrow register buses. The first is a byte-wide bus that reaches a 32-port span of legacy display-adapter I/O ports. Many of those ports work as index/data pairs. The second is a word-wide bus with two selects: an index register and a data port. Every access to it loads the index first and then moves data through the data port.

The host presents 1-, 2- or 4-byte little-endian reads and writes with a valid/ready handshake. The block breaks each access into a short, fixed-order sequence of back-end operations, one per clock. It gathers the read bytes into the returned word and raises ready once, one cycle after the last operation. A window-enable input gates the whole window. While it is low, accesses still complete, but nothing reaches either bus.

Top module: `mmio_legacy_bridge`

## Requirements
- R1: While reset is high, and in the cycles after it before any request, host_ready is low and neither leg_en nor ext_en is asserted.
- R2: A 1-byte access at window offset 0x400+k (k from 0 to 31) becomes exactly one byte operation on leg_port 0x3C0+k. A byte read returns that port's data in host_rdata[7:0] with the upper bits zero.
- R3: A 2-byte write at legacy offset A becomes a byte write of host_wdata[7:0] to port N in one cycle, then a byte write of host_wdata[15:8] to port N+1 in the next cycle. A byte whose offset falls outside the legacy span is skipped, but its cycle is still spent.
- R4: A 2-byte read at legacy offset A returns port N in bits 7:0 and port N+1 in bits 15:8, with bits 31:16 zero.
- R5: A word sub-access at offset 0x500+2i+b (i from 0 to 10) performs an index write of i with ext_sel=0 and ext_we=1. In the next cycle it performs the data access with ext_sel=1, which writes the 16-bit data or reads the 16-bit ext_rdata.
- R6: A 1-byte access to the extension area still runs the full word sub-access. A read returns ext_rdata[15:8] when offset bit 0 is 1, and ext_rdata[7:0] otherwise, in host_rdata[7:0]. A write sends {8'h00, host_wdata[7:0]}.
- R7: A 4-byte access (host_size 2 or 3) runs two 2-byte sub-accesses, at A and then at A+2. Each sub-access is routed by its own starting offset. The read result is {second, first}.
- R8: An access whose sub-access starting offset lies in neither area takes one cycle per sub-access. It performs no back-end operation and contributes zero read data.
- R9: When win_enable is low at acceptance, the access behaves as in R8 for every offset.
- R10: Back-end operations occur one per clock, starting the cycle after acceptance. host_ready is a one-cycle pulse that comes exactly one cycle after the last operation, so it arrives at operation count + 1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_enable | input | 1 | Window enable, sampled when a request is accepted |
| host_valid | input | 1 | Request present; hold it with the fields stable until host_ready |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 12 | Byte offset inside the window |
| host_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| host_wdata | input | 32 | Little-endian write data |
| host_ready | output | 1 | Completion pulse |
| host_rdata | output | 32 | Read data, valid while host_ready is high |
| leg_en | output | 1 | Byte-port operation strobe |
| leg_we | output | 1 | Byte-port write |
| leg_port | output | 16 | Byte-port I/O address |
| leg_wdata | output | 8 | Byte-port write data |
| leg_rdata | input | 8 | Byte-port read data, same cycle |
| ext_en | output | 1 | Indexed-bus operation strobe |
| ext_sel | output | 1 | 0 = index register, 1 = data port |
| ext_we | output | 1 | Indexed-bus write |
| ext_wdata | output | 16 | Index value or write data |
| ext_rdata | input | 16 | Indexed-bus read data, same cycle |

## Verification
The hardest case to reach is an index/data pair updated by one 2-byte write. It only shows up if the byte-port model reacts to ordering: the data port must use the index that was written one cycle earlier in the same access. The bench's port model keeps an indexed register file behind ports 0x3C4/0x3C5, and its word-bus model serves data according to its own index register. A wrong order or a wrong index therefore surfaces as wrong read-back data through the window, not only as a mismatched operation log. Accesses that straddle area boundaries (0x41F with 2 bytes, 0x514 with 4 bytes) reach the partial-skip paths.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_LEG  = 2'd1,
        REG_EXT  = 2'd2
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WRD2 = 2'd3
    } size_e;

    typedef struct packed {
        logic [31:0] wdata;
        logic        we;
        logic        en;
        size_e       size;
    } cmd_t;

    function automatic logic in_span(input int unsigned a, input int unsigned base,
                                     input int unsigned span);
        return (a >= base) && (a < base + span);
    endfunction

    function automatic logic is_wide(input size_e s);
        return (s == SZ_WORD) || (s == SZ_WRD2);
    endfunction

endpackage

// File: rtl/bridge_decode.sv
module bridge_decode
    import bridge_pkg::*;
#(
    parameter int AW        = 12,
    parameter int LEG_BASE  = 'h400,
    parameter int LEG_SPAN  = 32,
    parameter int EXT_BASE  = 'h500,
    parameter int EXT_REGS  = 11,
    parameter int IDX_W     = 16
) (
    input  logic [AW-1:0]    sub_addr,
    input  logic             enable,
    input  logic             single_byte,
    output region_e          region,
    output logic [1:0]       nops,
    output logic [IDX_W-1:0] ext_index
);
    localparam int EXT_SPAN = 2 * EXT_REGS;

    int unsigned a;
    always_comb begin
        a         = int'(sub_addr);
        ext_index = IDX_W'((a - EXT_BASE) >> 1);
        if (!enable) begin
            region = REG_NONE;
        end else if (in_span(a, LEG_BASE, LEG_SPAN)) begin
            region = REG_LEG;
        end else if (in_span(a, EXT_BASE, EXT_SPAN)) begin
            region = REG_EXT;
        end else begin
            region = REG_NONE;
        end
        case (region)
            REG_LEG: nops = single_byte ? 2'd1 : 2'd2;
            REG_EXT: nops = 2'd2;
            default: nops = 2'd1;
        endcase
    end
endmodule

// File: rtl/bridge_seq.sv
module bridge_seq
    import bridge_pkg::*;
#(
    parameter int AW        = 12,
    parameter int PORT_W    = 16,
    parameter int IDX_W     = 16,
    parameter int LEG_BASE  = 'h400,
    parameter int LEG_SPAN  = 32,
    parameter int LEG_PORT0 = 'h3C0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              win_enable,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [AW-1:0]     host_addr,
    input  logic [1:0]        host_size,
    input  logic [31:0]       host_wdata,
    output logic              host_ready,
    output logic [31:0]       host_rdata,
    output logic [AW-1:0]     sub_addr,
    output logic              sub_en,
    output logic              sub_byte,
    input  region_e           region,
    input  logic [1:0]        nops,
    input  logic [IDX_W-1:0]  ext_index,
    output logic              leg_en,
    output logic              leg_we,
    output logic [PORT_W-1:0] leg_port,
    output logic [7:0]        leg_wdata,
    input  logic [7:0]        leg_rdata,
    output logic              ext_en,
    output logic              ext_sel,
    output logic              ext_we,
    output logic [15:0]       ext_wdata,
    input  logic [15:0]       ext_rdata
);
    state_e        state;
    cmd_t          cmd;
    logic [AW-1:0] base;
    logic          half;
    logic          step;
    logic [31:0]   acc;
    logic [31:0]   acc_nxt;

    logic          run;
    logic          last_step;
    logic          last_half;
    logic [AW-1:0] byte_addr;
    logic          byte_hit;
    logic [1:0]    lane;

    assign run       = (state == ST_RUN);
    assign sub_addr  = base + (half ? AW'(2) : AW'(0));
    assign sub_en    = cmd.en;
    assign sub_byte  = (cmd.size == SZ_BYTE);
    assign byte_addr = sub_addr + AW'(step);
    assign byte_hit  = in_span(int'(byte_addr), LEG_BASE, LEG_SPAN);
    assign lane      = {half, step};
    assign last_step = (nops == 2'd1) || step;
    assign last_half = !is_wide(cmd.size) || half;

    // back-end drive
    always_comb begin
        leg_en    = run && (region == REG_LEG) && byte_hit;
        leg_we    = cmd.we;
        leg_port  = PORT_W'(int'(byte_addr) - LEG_BASE + LEG_PORT0);
        leg_wdata = cmd.wdata[{lane, 3'b000} +: 8];
        ext_en    = run && (region == REG_EXT);
        ext_sel   = step;
        ext_we    = !step || cmd.we;
        if (!step)
            ext_wdata = 16'(ext_index);
        else if (sub_byte)
            ext_wdata = {8'h00, cmd.wdata[7:0]};
        else
            ext_wdata = cmd.wdata[{half, 4'b0000} +: 16];
    end

    // read-data gathering
    always_comb begin
        acc_nxt = acc;
        if (leg_en && !cmd.we)
            acc_nxt[{lane, 3'b000} +: 8] = leg_rdata;
        if (ext_en && step && !cmd.we) begin
            if (sub_byte)
                acc_nxt[7:0] = sub_addr[0] ? ext_rdata[15:8] : ext_rdata[7:0];
            else
                acc_nxt[{half, 4'b0000} +: 16] = ext_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cmd   <= '0;
            base  <= '0;
            half  <= 1'b0;
            step  <= 1'b0;
            acc   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (host_valid) begin
                    cmd.wdata <= host_wdata;
                    cmd.we    <= host_write;
                    cmd.en    <= win_enable;
                    cmd.size  <= size_e'(host_size);
                    base      <= host_addr;
                    half      <= 1'b0;
                    step      <= 1'b0;
                    acc       <= '0;
                    state     <= ST_RUN;
                end
                ST_RUN: begin
                    acc <= acc_nxt;
                    if (last_step) begin
                        step <= 1'b0;
                        if (last_half) state <= ST_DONE;
                        else           half  <= 1'b1;
                    end else begin
                        step <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign host_ready = (state == ST_DONE);
    assign host_rdata = acc;

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        !(leg_en && ext_en)); // R10
    AST_INDEX_FIRST: assert property (@(posedge clk) disable iff (rst)
        (ext_en && ext_sel) |-> $past(ext_en && !ext_sel && ext_we)); // R5
    AST_PAIR_ASCENDS: assert property (@(posedge clk) disable iff (rst)
        (leg_en && step && $past(leg_en)) |-> (leg_port == $past(leg_port) + PORT_W'(1))); // R3
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        host_ready |=> !host_ready); // R10
    AST_QUIET_OFF: assert property (@(posedge clk) disable iff (rst)
        (run && !cmd.en) |-> (!leg_en && !ext_en)); // R9
    AST_PORT_SPAN: assert property (@(posedge clk) disable iff (rst)
        leg_en |-> (int'(leg_port) >= LEG_PORT0 && int'(leg_port) < LEG_PORT0 + LEG_SPAN)); // R2
endmodule

// File: rtl/mmio_legacy_bridge.sv
module mmio_legacy_bridge
    import bridge_pkg::*;
#(
    parameter int WIN_BYTES = 4096,
    parameter int PORT_W    = 16,
    parameter int LEG_BASE  = 'h400,
    parameter int LEG_SPAN  = 32,
    parameter int LEG_PORT0 = 'h3C0,
    parameter int EXT_BASE  = 'h500,
    parameter int EXT_REGS  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              win_enable,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [11:0]       host_addr,
    input  logic [1:0]        host_size,
    input  logic [31:0]       host_wdata,
    output logic              host_ready,
    output logic [31:0]       host_rdata,
    output logic              leg_en,
    output logic              leg_we,
    output logic [PORT_W-1:0] leg_port,
    output logic [7:0]        leg_wdata,
    input  logic [7:0]        leg_rdata,
    output logic              ext_en,
    output logic              ext_sel,
    output logic              ext_we,
    output logic [15:0]       ext_wdata,
    input  logic [15:0]       ext_rdata
);
    localparam int AW    = $clog2(WIN_BYTES);
    localparam int IDX_W = 16;

    logic [AW-1:0]    sub_addr;
    logic             sub_en;
    logic             sub_byte;
    region_e          region;
    logic [1:0]       nops;
    logic [IDX_W-1:0] ext_index;

    bridge_decode #(
        .AW(AW), .LEG_BASE(LEG_BASE), .LEG_SPAN(LEG_SPAN),
        .EXT_BASE(EXT_BASE), .EXT_REGS(EXT_REGS), .IDX_W(IDX_W)
    ) u_dec (
        .sub_addr(sub_addr), .enable(sub_en), .single_byte(sub_byte),
        .region(region), .nops(nops), .ext_index(ext_index)
    );

    bridge_seq #(
        .AW(AW), .PORT_W(PORT_W), .IDX_W(IDX_W), .LEG_BASE(LEG_BASE),
        .LEG_SPAN(LEG_SPAN), .LEG_PORT0(LEG_PORT0)
    ) u_seq (
        .clk(clk), .rst(rst), .win_enable(win_enable),
        .host_valid(host_valid), .host_write(host_write),
        .host_addr(AW'(host_addr)), .host_size(host_size), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_rdata(host_rdata),
        .sub_addr(sub_addr), .sub_en(sub_en), .sub_byte(sub_byte),
        .region(region), .nops(nops), .ext_index(ext_index),
        .leg_en(leg_en), .leg_we(leg_we), .leg_port(leg_port),
        .leg_wdata(leg_wdata), .leg_rdata(leg_rdata),
        .ext_en(ext_en), .ext_sel(ext_sel), .ext_we(ext_we),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
    );
endmodule

// File: tb/sim_mmio_legacy_bridge.sv
`timescale 1ns/1ps
module sim_mmio_legacy_bridge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        win_enable = 1'b1;
    logic        host_valid = 1'b0;
    logic        host_write = 1'b0;
    logic [11:0] host_addr  = '0;
    logic [1:0]  host_size  = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ready;
    logic [31:0] host_rdata;
    logic        leg_en, leg_we, ext_en, ext_sel, ext_we;
    logic [15:0] leg_port, ext_wdata, ext_rdata;
    logic [7:0]  leg_wdata, leg_rdata;

    always #2 clk = ~clk;

    mmio_legacy_bridge u0 (
        .clk(clk), .rst(rst), .win_enable(win_enable),
        .host_valid(host_valid), .host_write(host_write), .host_addr(host_addr),
        .host_size(host_size), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_rdata(host_rdata),
        .leg_en(leg_en), .leg_we(leg_we), .leg_port(leg_port),
        .leg_wdata(leg_wdata), .leg_rdata(leg_rdata),
        .ext_en(ext_en), .ext_sel(ext_sel), .ext_we(ext_we),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
    );

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";

    // behavioural back ends: plain bytes plus an indexed file behind 0x3C4/0x3C5
    logic [7:0]  pmem [32];
    logic [7:0]  pidx [8];
    logic [15:0] xidx;
    logic [15:0] xmem [11];

    function automatic logic [7:0] port_rd(input int p);
        if (p == 'h3C5) return pidx[pmem[4][2:0]];
        return pmem[p - 'h3C0];
    endfunction

    assign leg_rdata = (int'(leg_port) >= 'h3C0 && int'(leg_port) < 'h3E0) ? port_rd(int'(leg_port)) : 8'hEE;
    assign ext_rdata = !ext_sel ? xidx : (xidx < 11 ? xmem[xidx] : 16'hFFFF);

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 32; i++) pmem[i] <= 8'(i * 3 + 1);
            for (int i = 0; i < 8; i++)  pidx[i] <= 8'(8'h80 + i);
            for (int i = 0; i < 11; i++) xmem[i] <= 16'(16'h1000 + i);
            xidx <= '0;
        end else begin
            if (leg_en && leg_we) begin
                if (leg_port == 16'h3C5) pidx[pmem[4][2:0]] <= leg_wdata;
                else pmem[leg_port - 16'h3C0] <= leg_wdata;
            end
            if (ext_en && ext_we) begin
                if (!ext_sel) xidx <= ext_wdata;
                else if (xidx < 11) xmem[xidx] <= ext_wdata;
            end
        end
    end

    // expected operation log: [31:30] kind (1 port, 2 word bus), [29] we, [28:16] port or select, [15:0] data
    logic [31:0] exp_q [$];

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // per-clock comparison of back-end activity
    always @(negedge clk) begin
        if (!rst) begin
            logic [31:0] got;
            if (leg_en || ext_en) begin
                if (leg_en) got = {2'd1, leg_we, 13'(leg_port), leg_we ? {8'h00, leg_wdata} : 16'h0};
                else        got = {2'd2, ext_we, 13'(ext_sel), ext_we ? ext_wdata : 16'h0};
                if (exp_q.size() == 0) chk(1'b0, cur_tag, "unexpected op", got, 32'h0);
                else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(got == e, cur_tag, "op", got, e);
                end
            end
        end
    end

    task automatic xact(input logic [11:0] a, input logic [1:0] sz, input logic we,
                        input logic [31:0] wd, input logic en, input string tag,
                        output logic [31:0] rd);
        int ops = 0;
        int halves = (sz >= 2) ? 2 : 1;
        logic [31:0] er = '0;
        int cyc = 0;
        cur_tag = tag;
        for (int h = 0; h < halves; h++) begin
            int sa = (int'(a) + 2 * h) % 4096;
            if (!en) ops += 1;
            else if (sa >= 'h400 && sa < 'h420) begin
                int n = (sz == 0) ? 1 : 2;
                for (int s = 0; s < n; s++) begin
                    int b = sa + s;
                    int ln = 2 * h + s;
                    if (b >= 'h400 && b < 'h420) begin
                        exp_q.push_back({2'd1, we, 13'(b - 'h400 + 'h3C0),
                                         we ? {8'h00, wd[8*ln +: 8]} : 16'h0});
                        if (!we) er[8*ln +: 8] = port_rd(b - 'h400 + 'h3C0);
                    end
                end
                ops += n;
            end else if (sa >= 'h500 && sa < 'h516) begin
                int ix = (sa - 'h500) >> 1;
                logic [15:0] d = (sz == 0) ? {8'h00, wd[7:0]} : wd[16*h +: 16];
                exp_q.push_back({2'd2, 1'b1, 13'd0, 16'(ix)});
                exp_q.push_back({2'd2, we, 13'd1, we ? d : 16'h0});
                if (!we) begin
                    if (sz == 0) er[7:0] = sa[0] ? xmem[ix][15:8] : xmem[ix][7:0];
                    else er[16*h +: 16] = xmem[ix];
                end
                ops += 2;
            end else ops += 1;
        end
        win_enable = en; host_addr = a; host_size = sz; host_write = we;
        host_wdata = wd; host_valid = 1'b1;
        do begin
            @(negedge clk); cyc++;
        end while (!host_ready && cyc < 40);
        chk(cyc == ops + 1, "R10", $sformatf("%s latency", tag), 32'(cyc), 32'(ops + 1));
        chk(exp_q.size() == 0, tag, "missing ops", 32'(exp_q.size()), 32'h0);
        exp_q.delete();
        if (!we) chk(host_rdata == er, tag, "rdata", host_rdata, er);
        rd = host_rdata;
        host_valid = 1'b0; win_enable = 1'b1;
        @(negedge clk);
        chk(!host_ready, "R10", "ready single pulse", 32'(host_ready), 32'h0);
    endtask

    initial begin : wd_timer
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (4) @(negedge clk);
        chk(!host_ready && !leg_en && !ext_en, "R1", "in reset", {host_ready, leg_en, ext_en}, 32'h0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!host_ready && !leg_en && !ext_en, "R1", "after reset", {host_ready, leg_en, ext_en}, 32'h0);

        // R2 byte mapping, both span ends
        xact(12'h400, 2'd0, 1'b1, 32'h5A, 1'b1, "R2", r);
        xact(12'h400, 2'd0, 1'b0, 0, 1'b1, "R2", r);
        chk(r == 32'h5A, "R2", "byte readback", r, 32'h5A);
        xact(12'h41F, 2'd0, 1'b1, 32'hC9, 1'b1, "R2", r);
        xact(12'h41F, 2'd0, 1'b0, 0, 1'b1, "R2", r);

        // R3 index/data pair in one write: index 3, data C7
        xact(12'h404, 2'd1, 1'b1, 32'h0000C703, 1'b1, "R3", r);
        xact(12'h405, 2'd0, 1'b0, 0, 1'b1, "R3", r);
        chk(r == 32'hC7, "R3", "pair data landed", r, 32'hC7);
        xact(12'h41F, 2'd1, 1'b1, 32'h0000AA44, 1'b1, "R3", r);

        // R4 two-byte read
        xact(12'h404, 2'd1, 1'b0, 0, 1'b1, "R4", r);
        chk(r == 32'h0000C703, "R4", "pair read", r, 32'h0000C703);
        xact(12'h40A, 2'd1, 1'b0, 0, 1'b1, "R4", r);

        // R5 word bus, first and last registers
        xact(12'h504, 2'd1, 1'b1, 32'h1234, 1'b1, "R5", r);
        xact(12'h504, 2'd1, 1'b0, 0, 1'b1, "R5", r);
        chk(r == 32'h1234, "R5", "word readback", r, 32'h1234);
        xact(12'h514, 2'd1, 1'b1, 32'hA5C3, 1'b1, "R5", r);
        xact(12'h515, 2'd1, 1'b0, 0, 1'b1, "R5", r);
        xact(12'h500, 2'd1, 1'b0, 0, 1'b1, "R5", r);

        // R6 single byte on word bus
        xact(12'h505, 2'd0, 1'b0, 0, 1'b1, "R6", r);
        chk(r == 32'h12, "R6", "odd byte", r, 32'h12);
        xact(12'h506, 2'd0, 1'b1, 32'h77, 1'b1, "R6", r);
        xact(12'h506, 2'd1, 1'b0, 0, 1'b1, "R6", r);
        chk(r == 32'h0077, "R6", "zero-extended write", r, 32'h0077);

        // R7 four-byte accesses
        xact(12'h504, 2'd2, 1'b1, 32'hBEEF1234, 1'b1, "R7", r);
        xact(12'h504, 2'd3, 1'b0, 0, 1'b1, "R7", r);
        chk(r == 32'hBEEF1234, "R7", "word pair", r, 32'hBEEF1234);
        xact(12'h408, 2'd2, 1'b1, 32'h44332211, 1'b1, "R7", r);
        xact(12'h408, 2'd2, 1'b0, 0, 1'b1, "R7", r);
        xact(12'h514, 2'd2, 1'b0, 0, 1'b1, "R7", r);
        xact(12'h41E, 2'd2, 1'b0, 0, 1'b1, "R7", r);

        // R8 outside both areas
        xact(12'h000, 2'd2, 1'b0, 0, 1'b1, "R8", r);
        chk(r == 0, "R8", "outside reads zero", r, 0);
        xact(12'h600, 2'd1, 1'b1, 32'hFFFF, 1'b1, "R8", r);
        xact(12'h420, 2'd0, 1'b1, 32'h11, 1'b1, "R8", r);

        // R9 window disabled
        xact(12'h400, 2'd0, 1'b1, 32'h99, 1'b0, "R9", r);
        xact(12'h504, 2'd2, 1'b0, 0, 1'b0, "R9", r);
        chk(r == 0, "R9", "disabled read", r, 0);
        xact(12'h400, 2'd0, 1'b0, 0, 1'b1, "R9", r);
        chk(r == 32'h5A, "R9", "disabled write had no effect", r, 32'h5A);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule